// File: doc/BRIEF.md
# SDRAM command timing monitor

This block watches the command pins of a single-rank SDRAM interface and checks every sampled command against the device's ordering and minimum-spacing rules. It never drives the bus and holds no data. It decodes each rising-edge sample into a command and keeps a small tracker for every bank. Each tracker records whether the bank is idle, open, or closing on its own after an auto-precharge access. It also counts the cycles since the bank's last activate and since its last explicit precharge. Global counters cover the spacing after a mode register write and between activates.

Any rule break sets its own bit in a sticky flag word. The flags stay set until a synchronous clear arrives. A one-cycle pulse marks a violation that lands on an empty flag word, so a simulation or an on-chip trace can trigger on the first fault. All spacing limits are given as clock counts through parameters, and the number of banks follows from the bank-address width.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from the active-low pins (cs_n, ras_n, cas_n, we_n): 0000 mode write, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0110 burst stop, 0111 no-op. A sample with cs_n high, or with cke low, is a no-op and cannot raise any flag.
- R2: A mode write or refresh while any bank is not idle sets flag bit 1.
- R3: Any command other than a no-op fewer than T_MRD (2) cycles after a mode write sets flag bit 0.
- R4: A read or write to an open bank fewer than T_RCD (2) cycles after its activate sets flag bit 2.
- R5: An activate to an idle bank fewer than T_RP (2) cycles after its explicit precharge sets bit 3. An activate to a bank other than the last activated one, fewer than T_RRD (2) cycles after that activate, sets bit 4.
- R6: A precharge to an open bank fewer than T_RAS (5) cycles after its activate sets bit 5. An activate fewer than T_RC (7) cycles after the same bank's previous activate sets bit 6. Exactly T_RC cycles is legal.
- R7: A read or write with a10 high to an open bank starts an auto-precharge. The bank is busy until BURST_LEN+T_RP (6) cycles after that command, and an activate is accepted from that cycle. A read or write while it is busy sets bit 7.
- R8: A precharge with a10 high closes every open bank, whatever the value of ba.
- R9: A read or write to an idle bank, or an activate to a bank that is not idle, sets bit 8.
- R10: Flags appear in err_flags one cycle after the offending sample and stay set until clr. clr clears them, but a violation in the same cycle as clr is still recorded.
- R11: err_first pulses for one cycle when a violation is recorded while the flag word is empty, or while clr is high. err_any is high whenever any flag is set.
- R12: An active-low reset clears all flags and the pulse, and returns every bank to idle with its counters saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of the flag word |
| cke | input | 1 | Clock enable; low makes the sample a no-op |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks qualifier |
| err_flags | output | 9 | Sticky violation flags, bit per rule |
| err_any | output | 1 | OR of all flags |
| err_first | output | 1 | One-cycle pulse on the first recorded violation |

## Verification
The bench uses the default parameters: two bank-address bits, so four banks, T_RAS 5, T_RP 2, T_RC 7 and a burst of 4. With these values a precharge at the earliest legal cycle followed by an activate at the earliest legal cycle lands exactly on the row-cycle limit. That makes the legal T_RC boundary reachable, while breaking T_RC on its own needs an early precharge first. The short auto-precharge window of six cycles lets a single table cover a blocked access inside the window and a legal activate on its first free cycle.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

   typedef enum logic [2:0] {
      CMD_NOP, CMD_MRS, CMD_REF, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST
   } cmd_e;

   typedef enum logic [1:0] {BK_IDLE, BK_OPEN, BK_AUTO} bank_st_e;

   // flag word bit positions
   localparam int E_MRD   = 0;
   localparam int E_OPEN  = 1;
   localparam int E_RCD   = 2;
   localparam int E_RP    = 3;
   localparam int E_RRD   = 4;
   localparam int E_RAS   = 5;
   localparam int E_RC    = 6;
   localparam int E_AP    = 7;
   localparam int E_ORDER = 8;
   localparam int ERR_W   = 9;

   // per-bank violation vector positions
   localparam int BV_RCD   = 0;
   localparam int BV_RP    = 1;
   localparam int BV_RAS   = 2;
   localparam int BV_RC    = 3;
   localparam int BV_AP    = 4;
   localparam int BV_ORDER = 5;
   localparam int BV_W     = 6;

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
   import sdcm_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      cmd = CMD_NOP;
      if (cke && !cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
   import sdcm_pkg::*;
#(
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RAS     = 5,
   parameter int T_RC      = 7,
   parameter int BURST_LEN = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cmd_e            cmd,
   input  logic            hit,
   input  logic            a10,
   output logic [BV_W-1:0] viol,
   output logic            busy
);
   localparam int SAT = T_RCD + T_RP + T_RAS + T_RC + BURST_LEN;
   localparam int CW  = $clog2(SAT + 1);
   localparam logic [CW-1:0] C_SAT = CW'(SAT);
   localparam logic [CW-1:0] C_RCD = CW'(T_RCD);
   localparam logic [CW-1:0] C_RP  = CW'(T_RP);
   localparam logic [CW-1:0] C_RAS = CW'(T_RAS);
   localparam logic [CW-1:0] C_RC  = CW'(T_RC);
   localparam logic [CW-1:0] C_APL = CW'(BURST_LEN + T_RP - 1);
   localparam logic [CW-1:0] C_ONE = CW'(1);

   initial begin
      assert (BURST_LEN + T_RP >= 2) else $error("auto-precharge window too short");
      assert (T_RCD >= 1 && T_RP >= 1 && T_RAS >= 1 && T_RC >= 1) else $error("zero timing limit");
   end

   bank_st_e      st;
   logic [CW-1:0] act_cnt, pre_cnt, ap_cnt;
   logic          is_act, is_rw, is_pre;

   always_comb begin
      is_act = hit && (cmd == CMD_ACT);
      is_rw  = hit && (cmd == CMD_RD || cmd == CMD_WR);
      is_pre = (cmd == CMD_PRE) && (hit || a10);
      viol            = '0;
      viol[BV_RCD]    = is_rw && (st == BK_OPEN) && (act_cnt < C_RCD);
      viol[BV_AP]     = is_rw && (st == BK_AUTO);
      viol[BV_ORDER]  = (is_rw && st == BK_IDLE) || (is_act && st != BK_IDLE);
      viol[BV_RP]     = is_act && (st == BK_IDLE) && (pre_cnt < C_RP);
      viol[BV_RC]     = is_act && (act_cnt < C_RC);
      viol[BV_RAS]    = is_pre && (st == BK_OPEN) && (act_cnt < C_RAS);
      busy            = (st != BK_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= BK_IDLE;
         act_cnt <= C_SAT;
         pre_cnt <= C_SAT;
         ap_cnt  <= '0;
      end else begin
         if (act_cnt != C_SAT) act_cnt <= act_cnt + C_ONE;
         if (pre_cnt != C_SAT) pre_cnt <= pre_cnt + C_ONE;
         unique case (st)
            BK_IDLE: if (is_act) begin
               st      <= BK_OPEN;
               act_cnt <= C_ONE;
            end
            BK_OPEN: if (is_pre) begin
               st      <= BK_IDLE;
               pre_cnt <= C_ONE;
            end else if (is_rw && a10) begin
               st     <= BK_AUTO;
               ap_cnt <= C_APL;
            end
            BK_AUTO: if (ap_cnt <= C_ONE) st <= BK_IDLE;
                     else ap_cnt <= ap_cnt - C_ONE;
            default: st <= BK_IDLE;
         endcase
      end
   end

   // R7
   ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_AUTO && ap_cnt == C_ONE) |=> !busy);

   // R8
   pre_all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE && a10 && st == BK_OPEN) |=> !busy);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdcm_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int T_MRD     = 2,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RRD     = 2,
   parameter int T_RAS     = 5,
   parameter int T_RC      = 7,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BA_W-1:0]  ba,
   input  logic             a10,
   output logic [ERR_W-1:0] err_flags,
   output logic             err_any,
   output logic             err_first
);
   localparam int NBANK = 1 << BA_W;
   localparam int GSAT  = T_MRD + T_RRD;
   localparam int GW    = $clog2(GSAT + 1);
   localparam logic [GW-1:0] G_SAT = GW'(GSAT);
   localparam logic [GW-1:0] G_MRD = GW'(T_MRD);
   localparam logic [GW-1:0] G_RRD = GW'(T_RRD);
   localparam logic [GW-1:0] G_ONE = GW'(1);

   initial begin
      assert (BA_W >= 1 && BA_W <= 4) else $error("bank address width out of range");
      assert (T_MRD >= 1 && T_RRD >= 1) else $error("zero global timing limit");
   end

   cmd_e             cmd;
   logic [BV_W-1:0]  bv [NBANK];
   logic [NBANK-1:0] busy;
   logic [BV_W-1:0]  bv_or;
   logic [ERR_W-1:0] viol, err_q;
   logic [GW-1:0]    mrd_cnt, rrd_cnt;
   logic [BA_W-1:0]  last_ba;
   logic             first_q;

   sdcm_decode u_dec (
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      localparam logic [BA_W-1:0] MY_BA = BA_W'(g);
      sdcm_bank #(
         .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .BURST_LEN(BURST_LEN)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(ba == MY_BA), .a10(a10),
         .viol(bv[g]), .busy(busy[g])
      );
   end

   always_comb begin
      bv_or = '0;
      for (int i = 0; i < NBANK; i++) bv_or = bv_or | bv[i];
      viol          = '0;
      viol[E_MRD]   = (cmd != CMD_NOP) && (mrd_cnt < G_MRD);
      viol[E_OPEN]  = (cmd == CMD_MRS || cmd == CMD_REF) && (|busy);
      viol[E_RRD]   = (cmd == CMD_ACT) && (rrd_cnt < G_RRD) && (ba != last_ba);
      viol[E_RCD]   = bv_or[BV_RCD];
      viol[E_RP]    = bv_or[BV_RP];
      viol[E_RAS]   = bv_or[BV_RAS];
      viol[E_RC]    = bv_or[BV_RC];
      viol[E_AP]    = bv_or[BV_AP];
      viol[E_ORDER] = bv_or[BV_ORDER];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mrd_cnt <= G_SAT;
         rrd_cnt <= G_SAT;
         last_ba <= '0;
         err_q   <= '0;
         first_q <= 1'b0;
      end else begin
         if (cmd == CMD_MRS)        mrd_cnt <= G_ONE;
         else if (mrd_cnt != G_SAT) mrd_cnt <= mrd_cnt + G_ONE;
         if (cmd == CMD_ACT) begin
            rrd_cnt <= G_ONE;
            last_ba <= ba;
         end else if (rrd_cnt != G_SAT) rrd_cnt <= rrd_cnt + G_ONE;
         err_q   <= (clr ? '0 : err_q) | viol;
         first_q <= (|viol) && (clr || err_q == '0);
      end
   end

   assign err_flags = err_q;
   assign err_any   = |err_q;
   assign err_first = first_q;

   // R10
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

   // R10
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && viol == '0) |=> (err_flags == '0));

   // R11
   first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_first |-> err_any);

   // R11
   first_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_any) |-> err_first);

   // R1
   cke_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && !clr) |=> (err_flags == $past(err_flags)));

endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;

   localparam int NOP = 0, MRS = 1, REF = 2, ACT = 3, RD = 4, WR = 5, PRE = 6, BST = 7;
   localparam int NROW = 48;

   // row: clr, cke, cmd[3], ba[2], a10, req[4], exp[9]
   function automatic logic [20:0] rw(input int c, input int k, input int cm,
                                      input int b, input int a, input int rq, input int e);
      return {1'(c), 1'(k), 3'(cm), 2'(b), 1'(a), 4'(rq), 9'(e)};
   endfunction

   localparam logic [20:0] TBL [NROW] = '{
      rw(0,1,MRS,0,0, 3,'h000),  //  1
      rw(0,1,NOP,0,0, 3,'h000),  //  2
      rw(0,1,ACT,0,0, 3,'h000),  //  3 R3 boundary
      rw(0,1,NOP,0,0, 4,'h000),  //  4
      rw(0,1,RD ,0,0, 4,'h000),  //  5 R4 boundary
      rw(0,1,ACT,1,0, 5,'h000),  //  6 R5 rrd legal
      rw(0,1,NOP,0,0, 6,'h000),  //  7
      rw(0,1,PRE,0,0, 6,'h000),  //  8 R6 ras boundary
      rw(0,1,WR ,1,1, 7,'h000),  //  9 R7 auto-precharge
      rw(0,1,NOP,0,0, 7,'h000),  // 10
      rw(0,1,ACT,0,0, 5,'h000),  // 11
      rw(0,1,RD ,1,0, 7,'h080),  // 12 R7 blocked
      rw(1,1,NOP,0,0,10,'h000),  // 13 R10 clear
      rw(0,1,NOP,0,0,10,'h000),  // 14
      rw(0,1,ACT,1,0, 7,'h000),  // 15 R7 first free cycle
      rw(0,1,PRE,3,1, 6,'h020),  // 16 R6 ras via all-bank
      rw(1,1,NOP,0,0,10,'h000),  // 17
      rw(0,1,ACT,2,0, 5,'h000),  // 18
      rw(0,1,ACT,3,0, 5,'h010),  // 19 R5 rrd
      rw(1,1,NOP,0,0,10,'h000),  // 20
      rw(0,1,RD ,0,0, 8,'h100),  // 21 R8 bank 0 closed by all-bank precharge
      rw(1,1,NOP,0,0,10,'h000),  // 22
      rw(0,1,ACT,0,0, 5,'h000),  // 23
      rw(0,1,RD ,0,0, 4,'h004),  // 24 R4
      rw(1,1,NOP,0,0,10,'h000),  // 25
      rw(0,1,MRS,0,0, 2,'h002),  // 26 R2
      rw(0,1,BST,0,0, 3,'h003),  // 27 R3
      rw(1,1,NOP,0,0,10,'h000),  // 28
      rw(0,1,ACT,0,0, 9,'h140),  // 29 R9 + R6 rc
      rw(1,1,NOP,0,0,10,'h000),  // 30
      rw(0,1,PRE,2,0, 6,'h000),  // 31
      rw(0,1,ACT,2,0, 5,'h008),  // 32 R5 rp
      rw(1,1,NOP,0,0,10,'h000),  // 33
      rw(0,1,NOP,0,0,10,'h000),  // 34
      rw(0,1,NOP,0,0,10,'h000),  // 35
      rw(0,1,NOP,0,0,10,'h000),  // 36
      rw(0,1,PRE,2,0, 6,'h000),  // 37
      rw(0,1,NOP,0,0, 6,'h000),  // 38
      rw(0,1,ACT,2,0, 6,'h000),  // 39 R6 rc boundary
      rw(0,1,NOP,0,0, 6,'h000),  // 40
      rw(0,1,NOP,0,0, 6,'h000),  // 41
      rw(0,1,NOP,0,0, 6,'h000),  // 42
      rw(0,1,PRE,2,0, 6,'h020),  // 43 R6 ras
      rw(1,1,NOP,0,0,10,'h000),  // 44
      rw(0,1,ACT,2,0, 6,'h040),  // 45 R6 rc
      rw(1,1,NOP,0,0,10,'h000),  // 46
      rw(0,0,MRS,0,0, 1,'h000),  // 47 R1 cke low ignored
      rw(0,1,NOP,0,0, 1,'h000)   // 48
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0, clr = 1'b0, cke = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
   logic [1:0] ba = '0;
   logic [8:0] err_flags;
   logic       err_any, err_first;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   sdram_cmd_monitor uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
      .err_flags(err_flags), .err_any(err_any), .err_first(err_first)
   );

   task automatic drive(input int cm, input int b, input logic a, input logic k, input logic c);
      cs_n = 1'b0;
      case (cm)
         MRS:     {ras_n, cas_n, we_n} = 3'b000;
         REF:     {ras_n, cas_n, we_n} = 3'b001;
         ACT:     {ras_n, cas_n, we_n} = 3'b011;
         RD:      {ras_n, cas_n, we_n} = 3'b101;
         WR:      {ras_n, cas_n, we_n} = 3'b100;
         PRE:     {ras_n, cas_n, we_n} = 3'b010;
         BST:     {ras_n, cas_n, we_n} = 3'b110;
         default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
      ba = 2'(b); a10 = a; cke = k; clr = c;
   endtask

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 flags in reset", err_flags, 9'h000);
      check("R12 pulse in reset", {8'h0, err_first}, 9'h000);
      rst_n = 1'b1;
      for (int i = 0; i < NROW; i++) begin
         logic [20:0] r;
         r = TBL[i];
         drive(int'(r[18:16]), int'(r[15:14]), r[13], r[19], r[20]);
         @(negedge clk);
         check($sformatf("R%0d row %0d", r[12:9], i + 1), err_flags, r[8:0]);
      end
      // R1 cs_n high with a mode-write pattern while banks are open
      drive(MRS, 0, 1'b0, 1'b1, 1'b0);
      cs_n = 1'b1;
      @(negedge clk);
      check("R1 deselected", err_flags, 9'h000);
      // R11 first pulse on read of idle bank 1 (R9)
      drive(RD, 1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check("R9 idle read", err_flags, 9'h100);
      check("R11 first pulse", {7'h0, err_first, err_any}, 9'h003);
      drive(NOP, 0, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check("R11 pulse one cycle", {7'h0, err_first, err_any}, 9'h001);
      check("R10 sticky", err_flags, 9'h100);
      drive(RD, 1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check("R11 no pulse when flags set", {8'h0, err_first}, 9'h000);
      // R10 violation together with clear is kept
      drive(RD, 1, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      check("R10 clear with violation", err_flags, 9'h100);
      check("R11 pulse on clear", {8'h0, err_first}, 9'h001);
      // R12 reset mid-run
      drive(NOP, 0, 1'b0, 1'b1, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R12 flags after reset", err_flags, 9'h000);
      rst_n = 1'b1;
      drive(RD, 0, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      check("R12 banks idle after reset", err_flags, 9'h100);
      drive(NOP, 0, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule